// File: doc/BRIEF.md
# SLC-96 Transmit Data Link Inserter

This block supplies the bits carried in the signaling/data-link frame positions of transmitted SLC-96 superframes. Each transmitted sequence is 36 bits long: a 5-bit head marker, 24 data bits and a 7-bit tail marker. An external frame aligner marks which line-clock cycles are signaling/data-link slots and which slot opens a new sequence. The terminal frames in between are not handled here. For each marked slot, the block drives one bit and a valid strobe, one line clock later.

A host on its own processor clock fills a three-word stack. One word holds the head and tail markers, and two words hold twelve data bits each. The host then commits the stack with a control write. The commit crosses into the line domain as a toggle. The line side takes the new contents only at the first slot of a sequence, so a half-updated stack is never sent. Until the next commit arrives, the line side keeps resending the same contents. When an update has been taken for transmission, the host side raises a sticky stack-empty status, which is also the interrupt. The host clears it either by a status read in clear-on-read mode or by a clear write.

Top module: `slc_dl_tx`

## Requirements
- R1: After reset, `l_bit`, `l_bit_vld`, `h_busy` and `h_irq` are all 0. The stack resets to marker word 0x38E0 (head 00111, tail 0001110) and to all-zero data words.
- R2: Sequence bit k (k = 0..35) is sent in this order:
  - word 0 bits 15..11 (the head);
  - word 1 bits 15..4;
  - word 2 bits 15..4;
  - word 0 bits 10..4 (the tail).
  Each field is sent most significant bit first. Word addresses are 0..2 on `h_addr`.
- R3: A cycle with `l_fs_slot`=1 and `l_ins_en`=1 gives `l_bit_vld`=1, carrying that slot's bit, in the next line cycle. Otherwise `l_bit_vld` is 0. The sequence position advances by one per slot, wraps from 35 to 0, and does not move on other cycles.
- R4: A slot with `l_seq_start`=1 sends sequence bit 0, whatever the previous position was.
- R5: When no commit is pending, the stored contents are sent again, unchanged, in every following sequence.
- R6: A commit is written as address 3 with data bit 0 set. Committed contents appear from the next sequence bit 0 sent with insertion enabled. The remaining bits of the current sequence still come from the old contents.
- R7: `h_busy` is 1 from the cycle after a commit until the line side has taken the update. While it is 1, stack writes and further commits are ignored.
- R8: `h_irq` rises in the same host cycle in which `h_busy` falls after an update has been taken.
- R9: With `h_cor`=1, a read strobe on `h_rd` clears `h_irq` in the next host cycle. With `h_cor`=0, a read strobe leaves it set. A write to address 3 with data bit 1 set clears it in either mode.
- R10: While `l_ins_en`=0, `l_bit` and `l_bit_vld` stay 0 and a pending update is not taken. The update is taken at the first enabled bit-0 slot.
- R11: Bits 3..0 of the stack words are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Host (processor) clock |
| hrst_n | input | 1 | Host-domain asynchronous active-low reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 2 | Host address: 0..2 stack words, 3 control |
| h_wdata | input | 16 | Host write data |
| h_rd | input | 1 | Status read strobe |
| h_cor | input | 1 | Clear-on-read select for the status |
| h_busy | output | 1 | Committed update not yet taken by the line side |
| h_irq | output | 1 | Sticky stack-empty status and interrupt |
| lclk | input | 1 | Line clock |
| lrst_n | input | 1 | Line-domain asynchronous active-low reset |
| l_ins_en | input | 1 | Insertion enable |
| l_fs_slot | input | 1 | This line cycle is a signaling/data-link slot |
| l_seq_start | input | 1 | With `l_fs_slot`, this slot starts a new sequence |
| l_bit | output | 1 | Serial data-link bit |
| l_bit_vld | output | 1 | `l_bit` carries a slot's bit |

## Verification
The bench uses the default parameters: 16-bit words with 12-bit fields, a 5/7 head/tail split, two data words and two-stage synchronizers. A full 36-slot sequence is therefore short enough to run many times. Within one run this reaches:
- wrap-around retransmission;
- a commit made mid-sequence;
- write lockout while an update is pending;
- an update held back across a disabled sequence;
- a forced restart of the sequence.

Its host clock is faster than the line clock, so the handshake latency stays well inside the gaps the bench leaves before each sequence start.

// File: rtl/slc_dl_pkg.sv
package slc_dl_pkg;
  // Default geometry of the transmit stack and of one sequence
  localparam int DEF_WORD_W   = 16;
  localparam int DEF_FIELD_W  = 12;
  localparam int DEF_HEAD_W   = 5;
  localparam int DEF_N_DWORDS = 2;
  localparam int DEF_SYNC     = 2;
  // Head marker 00111 followed by tail marker 0001110
  localparam logic [DEF_FIELD_W-1:0] DEF_MARK = 12'b00111_0001110;
endpackage

// File: rtl/slc_dl_sync.sv
module slc_dl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/slc_dl_host.sv
module slc_dl_host #(
  parameter int WORD_W  = 16,
  parameter int FIELD_W = 12,
  parameter int N_WORDS = 3,
  parameter int ADDR_W  = 2,
  parameter int SYNC    = 2,
  parameter logic [FIELD_W-1:0] MARK_RST = '0
) (
  input  logic                            hclk,
  input  logic                            hrst_n,
  input  logic                            wr,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [WORD_W-1:0]               wdata,
  input  logic                            rd,
  input  logic                            cor,
  input  logic                            ack_tgl_in,
  output logic [N_WORDS-1:0][FIELD_W-1:0] shadow,
  output logic                            req_tgl,
  output logic                            busy,
  output logic                            irq
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_WORDS);

  logic [N_WORDS-1:0][FIELD_W-1:0] shadow_q, shadow_d;
  logic busy_q, busy_d;
  logic req_q, req_d;
  logic sts_q, sts_d;
  logic ack_s, ack_q;
  logic ctrl_hit, commit, wclr, rclr, ack_edge;
  logic unused_lo;

  // Bits below the field are ignored by the stack
  assign unused_lo = ^wdata[WORD_W-FIELD_W-1:0];

  slc_dl_sync #(.STAGES(SYNC)) u_ack_sync (
    .clk   (hclk),
    .rst_n (hrst_n),
    .d     (ack_tgl_in),
    .q     (ack_s)
  );

  always_comb begin
    ctrl_hit = wr && (addr == CTRL_ADDR);
    commit   = ctrl_hit && wdata[0] && !busy_q;
    wclr     = ctrl_hit && wdata[1];
    rclr     = rd && cor;
    ack_edge = ack_s ^ ack_q;
  end

  // Stack words: one shadow register per word
  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    localparam logic [FIELD_W-1:0] RV = (k == 0) ? MARK_RST : '0;
    logic we;

    always_comb begin
      we          = wr && (addr == ADDR_W'(k)) && !busy_q;
      shadow_d[k] = we ? wdata[WORD_W-1 -: FIELD_W] : shadow_q[k];
    end

    always_ff @(posedge hclk or negedge hrst_n) begin
      if (!hrst_n) begin
        shadow_q[k] <= RV;
      end else if (we) begin
        shadow_q[k] <= shadow_d[k];
      end
    end
  end

  always_comb begin
    req_d  = req_q ^ commit;
    busy_d = busy_q;
    if (commit) begin
      busy_d = 1'b1;
    end else if (ack_edge) begin
      busy_d = 1'b0;
    end
    sts_d = sts_q;
    if (ack_edge) begin
      sts_d = 1'b1;
    end else if (rclr || wclr) begin
      sts_d = 1'b0;
    end
  end

  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n) begin
      req_q  <= 1'b0;
      busy_q <= 1'b0;
      sts_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      req_q  <= req_d;
      busy_q <= busy_d;
      sts_q  <= sts_d;
      ack_q  <= ack_s;
    end
  end

  assign shadow  = shadow_q;
  assign req_tgl = req_q;
  assign busy    = busy_q;
  assign irq     = sts_q;
endmodule

// File: rtl/slc_dl_seq.sv
module slc_dl_seq #(
  parameter int FIELD_W = 12,
  parameter int HEAD_W  = 5,
  parameter int N_WORDS = 3,
  parameter int SEQ_LEN = 36
) (
  input  logic [N_WORDS-1:0][FIELD_W-1:0] words,
  output logic [SEQ_LEN-1:0]              seq
);
  localparam int TAIL_W = FIELD_W - HEAD_W;

  // Head sits at the top, tail at the bottom, data fields between
  assign seq[SEQ_LEN-1 -: HEAD_W] = words[0][FIELD_W-1 -: HEAD_W];
  assign seq[TAIL_W-1:0]          = words[0][TAIL_W-1:0];

  for (genvar k = 1; k < N_WORDS; k++) begin : g_field
    assign seq[SEQ_LEN-1-HEAD_W-(k-1)*FIELD_W -: FIELD_W] = words[k];
  end
endmodule

// File: rtl/slc_dl_line.sv
module slc_dl_line #(
  parameter int FIELD_W = 12,
  parameter int HEAD_W  = 5,
  parameter int N_WORDS = 3,
  parameter int SEQ_LEN = 36,
  parameter int CNT_W   = 6,
  parameter int SYNC    = 2,
  parameter logic [FIELD_W-1:0] MARK_RST = '0
) (
  input  logic                            lclk,
  input  logic                            lrst_n,
  input  logic                            ins_en,
  input  logic                            fs_slot,
  input  logic                            seq_start,
  input  logic                            req_tgl_in,
  input  logic [N_WORDS-1:0][FIELD_W-1:0] shadow_in,
  output logic                            ack_tgl,
  output logic                            bit_o,
  output logic                            vld_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_LEN - 1);

  logic [N_WORDS-1:0][FIELD_W-1:0] active_q, active_d, src;
  logic [SEQ_LEN-1:0] seq_vec;
  logic [CNT_W-1:0]   cnt_q, cnt_d, idx_now, sel;
  logic req_s, req_q, req_edge;
  logic pend_q, pend_d;
  logic ack_q, ack_d;
  logic bit_q, bit_d, vld_q, vld_d;
  logic slot_on, swap;

  slc_dl_sync #(.STAGES(SYNC)) u_req_sync (
    .clk   (lclk),
    .rst_n (lrst_n),
    .d     (req_tgl_in),
    .q     (req_s)
  );

  slc_dl_seq #(
    .FIELD_W (FIELD_W),
    .HEAD_W  (HEAD_W),
    .N_WORDS (N_WORDS),
    .SEQ_LEN (SEQ_LEN)
  ) u_seq (
    .words (src),
    .seq   (seq_vec)
  );

  always_comb begin
    req_edge = req_s ^ req_q;
    idx_now  = seq_start ? '0 : cnt_q;
    slot_on  = fs_slot && ins_en;
    // Update taken only at the first bit of an enabled sequence
    swap     = slot_on && (idx_now == '0) && pend_q;
    src      = swap ? shadow_in : active_q;
    active_d = src;
    sel      = LAST - idx_now;

    pend_d = pend_q;
    if (req_edge) begin
      pend_d = 1'b1;
    end else if (swap) begin
      pend_d = 1'b0;
    end

    cnt_d = cnt_q;
    if (fs_slot) begin
      cnt_d = (idx_now == LAST) ? '0 : idx_now + CNT_W'(1);
    end

    ack_d = ack_q ^ swap;
    vld_d = slot_on;
    bit_d = slot_on ? seq_vec[sel] : 1'b0;
  end

  always_ff @(posedge lclk or negedge lrst_n) begin
    if (!lrst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      req_q  <= req_s;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      ack_q  <= ack_d;
      bit_q  <= bit_d;
      vld_q  <= vld_d;
    end
  end

  for (genvar k = 0; k < N_WORDS; k++) begin : g_act
    localparam logic [FIELD_W-1:0] RV = (k == 0) ? MARK_RST : '0;
    always_ff @(posedge lclk or negedge lrst_n) begin
      if (!lrst_n) begin
        active_q[k] <= RV;
      end else if (swap) begin
        active_q[k] <= active_d[k];
      end
    end
  end

  assign ack_tgl = ack_q;
  assign bit_o   = bit_q;
  assign vld_o   = vld_q;
endmodule

// File: rtl/slc_dl_tx.sv
module slc_dl_tx
  import slc_dl_pkg::*;
#(
  parameter int WORD_W   = DEF_WORD_W,
  parameter int FIELD_W  = DEF_FIELD_W,
  parameter int HEAD_W   = DEF_HEAD_W,
  parameter int N_DWORDS = DEF_N_DWORDS,
  parameter int SYNC     = DEF_SYNC,
  parameter logic [FIELD_W-1:0] MARK_RST = DEF_MARK,
  parameter int ADDR_W   = $clog2(N_DWORDS + 2)
) (
  input  logic              hclk,
  input  logic              hrst_n,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [WORD_W-1:0] h_wdata,
  input  logic              h_rd,
  input  logic              h_cor,
  output logic              h_busy,
  output logic              h_irq,
  input  logic              lclk,
  input  logic              lrst_n,
  input  logic              l_ins_en,
  input  logic              l_fs_slot,
  input  logic              l_seq_start,
  output logic              l_bit,
  output logic              l_bit_vld
);
  localparam int N_WORDS = N_DWORDS + 1;
  localparam int SEQ_LEN = N_WORDS * FIELD_W;
  localparam int CNT_W   = $clog2(SEQ_LEN);

  logic [N_WORDS-1:0][FIELD_W-1:0] shadow;
  logic req_tgl, ack_tgl;

  slc_dl_host #(
    .WORD_W   (WORD_W),
    .FIELD_W  (FIELD_W),
    .N_WORDS  (N_WORDS),
    .ADDR_W   (ADDR_W),
    .SYNC     (SYNC),
    .MARK_RST (MARK_RST)
  ) u_host (
    .hclk       (hclk),
    .hrst_n     (hrst_n),
    .wr         (h_wr),
    .addr       (h_addr),
    .wdata      (h_wdata),
    .rd         (h_rd),
    .cor        (h_cor),
    .ack_tgl_in (ack_tgl),
    .shadow     (shadow),
    .req_tgl    (req_tgl),
    .busy       (h_busy),
    .irq        (h_irq)
  );

  slc_dl_line #(
    .FIELD_W  (FIELD_W),
    .HEAD_W   (HEAD_W),
    .N_WORDS  (N_WORDS),
    .SEQ_LEN  (SEQ_LEN),
    .CNT_W    (CNT_W),
    .SYNC     (SYNC),
    .MARK_RST (MARK_RST)
  ) u_line (
    .lclk       (lclk),
    .lrst_n     (lrst_n),
    .ins_en     (l_ins_en),
    .fs_slot    (l_fs_slot),
    .seq_start  (l_seq_start),
    .req_tgl_in (req_tgl),
    .shadow_in  (shadow),
    .ack_tgl    (ack_tgl),
    .bit_o      (l_bit),
    .vld_o      (l_bit_vld)
  );
endmodule

// File: rtl/slc_dl_tx_chk.sv
module slc_dl_tx_chk #(
  parameter int ADDR_W = 2,
  parameter int CTRL   = 3
) (
  input logic              hclk,
  input logic              hrst_n,
  input logic              h_wr,
  input logic [ADDR_W-1:0] h_addr,
  input logic              commit_bit,
  input logic              h_rd,
  input logic              h_cor,
  input logic              h_busy,
  input logic              h_irq,
  input logic              lclk,
  input logic              lrst_n,
  input logic              l_ins_en,
  input logic              l_fs_slot,
  input logic              l_bit,
  input logic              l_bit_vld
);
  // R3
  slot_vld_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
    (l_fs_slot && l_ins_en) |=> l_bit_vld);

  // R3
  no_slot_quiet_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
    !l_fs_slot |=> !l_bit_vld);

  // R10
  dis_quiet_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
    !l_ins_en |=> (!l_bit_vld && !l_bit));

  // R10
  idle_zero_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
    !l_bit_vld |-> !l_bit);

  // R7
  commit_busy_chk: assert property (@(posedge hclk) disable iff (!hrst_n)
    (h_wr && (h_addr == ADDR_W'(CTRL)) && commit_bit) |=> h_busy);

  // R8
  irq_rise_chk: assert property (@(posedge hclk) disable iff (!hrst_n)
    $rose(h_irq) |-> $fell(h_busy));

  // R9
  cor_clear_chk: assert property (@(posedge hclk) disable iff (!hrst_n)
    (h_rd && h_cor && !h_busy) |=> !h_irq);

  // R9
  rd_keep_chk: assert property (@(posedge hclk) disable iff (!hrst_n)
    (h_rd && !h_cor && h_irq && !h_wr) |=> h_irq);
endmodule

bind slc_dl_tx slc_dl_tx_chk #(
  .ADDR_W (ADDR_W),
  .CTRL   (N_DWORDS + 1)
) u_chk (
  .hclk       (hclk),
  .hrst_n     (hrst_n),
  .h_wr       (h_wr),
  .h_addr     (h_addr),
  .commit_bit (h_wdata[0]),
  .h_rd       (h_rd),
  .h_cor      (h_cor),
  .h_busy     (h_busy),
  .h_irq      (h_irq),
  .lclk       (lclk),
  .lrst_n     (lrst_n),
  .l_ins_en   (l_ins_en),
  .l_fs_slot  (l_fs_slot),
  .l_bit      (l_bit),
  .l_bit_vld  (l_bit_vld)
);

// File: tb/slc_dl_tx_tb.sv
module slc_dl_tx_tb;
  logic        hclk, hrst_n, h_wr, h_rd, h_cor;
  logic [1:0]  h_addr;
  logic [15:0] h_wdata;
  logic        h_busy, h_irq;
  logic        lclk, lrst_n, l_ins_en, l_fs_slot, l_seq_start;
  logic        l_bit, l_bit_vld;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // Expected-item scoreboard
  bit    exp_q[$];
  string tag_q[$];
  int    pos_q[$];

  // Bench model of the stack
  logic [15:0] m_sh [3];
  logic [15:0] m_cm [3];
  logic [15:0] m_act[3];
  bit m_pend, m_busy;
  int b_idx;

  slc_dl_tx u_dut (
    .hclk(hclk), .hrst_n(hrst_n), .h_wr(h_wr), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rd(h_rd), .h_cor(h_cor), .h_busy(h_busy),
    .h_irq(h_irq), .lclk(lclk), .lrst_n(lrst_n), .l_ins_en(l_ins_en),
    .l_fs_slot(l_fs_slot), .l_seq_start(l_seq_start), .l_bit(l_bit),
    .l_bit_vld(l_bit_vld)
  );

  initial begin
    hclk = 1'b0;
    forever #10 hclk = ~hclk;
  end

  initial begin
    lclk = 1'b0;
    forever #16 lclk = ~lclk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_bit(input int idx);
    logic [35:0] v;
    v = {m_act[0][15:11], m_act[1][15:4], m_act[2][15:4], m_act[0][10:4]};
    return v[35-idx];
  endfunction

  // Monitor: compare each valid bit against the scoreboard
  always @(negedge lclk) begin
    if (lrst_n && l_bit_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected valid", 1, 0);
      end else begin
        automatic bit    e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        automatic int    p = pos_q.pop_front();
        check(l_bit == e, $sformatf("%s bit %0d", t, p), int'(l_bit), int'(e));
      end
    end
  end

  task automatic hwrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge hclk);
    h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(negedge hclk);
    h_wr = 1'b0;
    if (!m_busy) begin
      if (a < 2'd3) m_sh[a] = d;
      else if (d[0]) begin
        for (int k = 0; k < 3; k++) m_cm[k] = m_sh[k];
        m_busy = 1; m_pend = 1;
      end
    end
  endtask

  task automatic hread(input logic cor);
    @(negedge hclk);
    h_rd = 1'b1; h_cor = cor;
    @(negedge hclk);
    h_rd = 1'b0;
  endtask

  // Driver: one slot, expected bit pushed to the scoreboard
  task automatic send_slot(input bit start, input int gap, input string tag);
    int idx;
    @(negedge lclk);
    l_fs_slot = 1'b1; l_seq_start = start;
    idx = start ? 0 : b_idx;
    if (l_ins_en) begin
      if (idx == 0 && m_pend) begin
        for (int k = 0; k < 3; k++) m_act[k] = m_cm[k];
        m_pend = 0; m_busy = 0;
      end
      exp_q.push_back(exp_bit(idx));
      tag_q.push_back(tag);
      pos_q.push_back(idx);
    end
    b_idx = (idx == 35) ? 0 : idx + 1;
    @(negedge lclk);
    l_fs_slot = 1'b0; l_seq_start = 1'b0;
    if (!l_ins_en) check(!l_bit_vld && !l_bit, "R10 disabled output", int'(l_bit_vld), 0);
    repeat (gap) @(negedge lclk);
  endtask

  task automatic send_run(input int n, input bit first_start, input string tag);
    for (int i = 0; i < n; i++) send_slot(first_start && i == 0, 1 + (i % 3), tag);
  endtask

  initial begin
    #(4_000_000);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    hrst_n = 0; lrst_n = 0; h_wr = 0; h_rd = 0; h_cor = 0; h_addr = 0; h_wdata = 0;
    l_ins_en = 0; l_fs_slot = 0; l_seq_start = 0;
    m_sh[0] = 16'h38E0; m_sh[1] = 0; m_sh[2] = 0;
    for (int k = 0; k < 3; k++) begin m_act[k] = m_sh[k]; m_cm[k] = m_sh[k]; end
    m_pend = 0; m_busy = 0; b_idx = 0;
    repeat (3) @(negedge lclk);
    lrst_n = 1;
    @(negedge hclk);
    hrst_n = 1;
    @(negedge lclk);
    // R1 reset state
    check(l_bit == 0 && l_bit_vld == 0, "R1 line outputs", int'(l_bit_vld), 0);
    check(h_busy == 0, "R1 busy", int'(h_busy), 0);
    check(h_irq == 0, "R1 irq", int'(h_irq), 0);

    // R2 default markers, R3 slot pacing, R5 retransmission on wrap
    l_ins_en = 1;
    send_run(36, 1, "R2");
    send_run(36, 0, "R5");

    // R6 mid-sequence commit, R7 write lockout, R11 low bits ignored
    hwrite(2'd1, 16'hA5A7);
    hwrite(2'd2, 16'h3C7B);
    send_run(10, 1, "R6 old");
    hwrite(2'd3, 16'h0001);
    check(h_busy == 1, "R7 busy after commit", int'(h_busy), 1);
    hwrite(2'd2, 16'hFFF0);
    send_run(26, 0, "R6 old tail");
    send_run(36, 0, "R11 new");
    repeat (10) @(negedge hclk);
    check(h_busy == 0, "R7 busy released", int'(h_busy), 0);
    check(h_irq == 1, "R8 empty raised", int'(h_irq), 1);
    send_run(36, 0, "R7 write ignored");

    // R9 status clearing modes
    hread(1'b0);
    check(h_irq == 1, "R9 read without cor", int'(h_irq), 1);
    hread(1'b1);
    check(h_irq == 0, "R9 clear on read", int'(h_irq), 0);

    // R10 pending update held while disabled
    hwrite(2'd0, 16'hE2B5);
    hwrite(2'd1, 16'h0F0F);
    hwrite(2'd2, 16'h1234);
    hwrite(2'd3, 16'h0001);
    repeat (8) @(negedge lclk);
    l_ins_en = 0;
    send_run(36, 1, "R10");
    repeat (10) @(negedge hclk);
    check(h_busy == 1, "R10 update held", int'(h_busy), 1);
    check(h_irq == 0, "R10 no empty event", int'(h_irq), 0);
    l_ins_en = 1;
    send_run(36, 1, "R10 taken");
    repeat (10) @(negedge hclk);
    check(h_irq == 1, "R8 second event", int'(h_irq), 1);
    hwrite(2'd3, 16'h0002);
    check(h_irq == 0, "R9 clear by write", int'(h_irq), 0);

    // R4 forced restart mid-sequence
    send_run(7, 1, "R4 pre");
    send_run(20, 1, "R4 restart");
    send_run(5, 1, "R4 again");

    repeat (6) @(negedge lclk);
    check(exp_q.size() == 0, "R3 all slots emitted", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule